// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short first-in first-out record of finished transmissions. Each time the transmit engine reports a completion, the block stores one status byte. The byte holds the error flags of that frame and the frame's request for an interrupt on success. The host reads the oldest stored byte at a byte-wide status port. Any write strobe on that port discards the entry being shown, and the next one moves up.

The stack is four entries deep by default. A completion that arrives when no slot is free is lost. The loss is recorded by setting an overflow bit in the newest entry still held. Jabber and underrun are fatal to the transmitter. Either one latches a transmitter-off indication, and that indication stays set until a TX reset. The TX reset also empties the stack. The block raises a completion event while the visible entry is worth the host's attention.

Top module: `tx_cmpl_stack`

## Requirements
- R1: A stored status byte has this layout: bit 7 = 1 (entry valid), bit 6 = interrupt-on-success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions reached, bit 2 = stack overflow, bits 1:0 = 0. Each flag is taken from the completion inputs. The stored byte appears at `sts_byte` in the cycle after the completion is sampled, if the stack was empty.
- R2: Entries are presented oldest first, and up to DEPTH (4) entries are held at once.
- R3: A `host_wr` strobe removes the entry being shown, and the next entry is visible one cycle later. A strobe on an empty stack has no effect.
- R4: When the stack is empty, `sts_byte` reads 8'h00.
- R5: A completion that arrives while the stack is full, with no pop in the same cycle, is discarded. Bit 2 of the newest stored entry becomes 1, and all other entries are unchanged.
- R6: A completion that arrives while the stack is full, together with a pop in the same cycle, is stored, and overflow is not flagged.
- R7: `tx_cmp_evt` is 1 exactly when the stack is non-empty and the shown entry has any of bits 6 to 2 set.
- R8: A completion carrying jabber or underrun sets `tx_off` from the next cycle on, even when the entry itself is dropped. `tx_off` stays set until a TX reset.
- R9: `tx_reset` empties the stack and clears `tx_off` from the next cycle on. A completion sampled in the same cycle is discarded, both as an entry and as a cause of `tx_off`.
- R10: After `rst_n` low, the stack is empty, `sts_byte` is 0, `tx_cmp_evt` is 0 and `tx_off` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | A transmission finished this cycle |
| cmp_irq_req | input | 1 | Frame asked for an interrupt on success |
| cmp_jabber | input | 1 | Frame ended in a jabber error |
| cmp_underrun | input | 1 | Frame ended in a transmit underrun |
| cmp_max_coll | input | 1 | Frame hit the collision limit |
| host_wr | input | 1 | Host write strobe on the status port (pops) |
| tx_reset | input | 1 | Transmitter reset command |
| sts_byte | output | 8 | Oldest status byte, or 0 when empty |
| tx_cmp_evt | output | 1 | Shown entry needs host attention |
| tx_off | output | 1 | Transmitter held off by jabber or underrun |

## Verification
The hardest condition to reach from the ports is a full stack meeting further completions. Within that condition, the case that matters most is a pop arriving in the same cycle as a completion, because that cycle decides between storing the completion and marking overflow. The stimulus fills four entries with distinct flag patterns, then sends completions with and without a simultaneous pop, and then drains the stack to confirm that the overflow bit landed only on the newest entry. A long pseudo-random run with rare TX resets then mixes pushes, pops and resets, and a queue model in the bench predicts every output byte.

// File: rtl/tcs_pkg.sv
// Shared types for the transmit completion status stack.
// Assumes a status byte of eight bits with two reserved low bits.
package tcs_pkg;
    // Flags held per stored completion, in status-byte order (bit 6 down to bit 2).
    typedef struct packed {
        logic irq_req;
        logic jabber;
        logic underrun;
        logic max_coll;
        logic ovf;
    } tcs_flags_t;

    localparam int FLAG_W = $bits(tcs_flags_t);
endpackage

// File: rtl/tcs_entry.sv
// One storage slot of the status stack.
// Loads a new flag set on a write, or only raises its overflow flag on a mark.
// Assumes the parent never asserts wr_en and mark_ovf together.
module tcs_entry
    import tcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  tcs_flags_t wr_flags,
    input  logic       mark_ovf,
    output tcs_flags_t flags_q
);
    // Slot register: load on write, set the overflow flag on mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q <= wr_flags;
        end else if (mark_ovf) begin
            flags_q.ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/tcs_fifo.sv
// Circular first-in first-out store of completion flags, DEPTH slots deep.
// Pushes while full are dropped, and the drop marks overflow on the newest slot.
// A pop in the same cycle frees room for the push. A clear empties the store.
module tcs_fifo
    import tcs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  tcs_flags_t push_flags,
    input  logic       pop,
    output logic       empty,
    output tcs_flags_t head_flags
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] rd_ptr, wr_ptr, newest;
    logic [CNT_W-1:0] cnt;
    logic             full, pop_ok, push_ok, drop;
    tcs_flags_t       slot_q [DEPTH];

    // Status of the store and the accept/drop decision for this cycle.
    always_comb begin
        full    = (cnt == FULL_CNT);
        empty   = (cnt == '0);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        drop    = push && full && !pop_ok;
        newest  = (wr_ptr == '0) ? LAST : wr_ptr - PTR_W'(1);
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            if (push_ok && !pop_ok)      cnt <= cnt + CNT_W'(1);
            else if (pop_ok && !push_ok) cnt <= cnt - CNT_W'(1);
        end
    end

    // One slot per stack position.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        tcs_entry u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (push_ok && !clr && (wr_ptr == PTR_W'(i))),
            .wr_flags (push_flags),
            .mark_ovf (drop && !clr && (newest == PTR_W'(i))),
            .flags_q  (slot_q[i])
        );
    end

    assign head_flags = slot_q[rd_ptr];

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    // R5
    drop_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !clr) |=> (cnt == FULL_CNT));

    // R3
    idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty);
endmodule

// File: rtl/tcs_fault_latch.sv
// Holds the transmitter off after a jabber or underrun completion.
// Assumes a TX reset outranks a fault reported in the same cycle.
module tcs_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fault,
    output logic tx_off
);
    // Set on a fault, release only on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) tx_off <= 1'b0;
        else if (fault)    tx_off <= 1'b1;
    end

    // R8
    fault_sets_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clr) |=> tx_off);

    // R8
    off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_off && !clr) |=> tx_off);

    // R9
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tx_off);
endmodule

// File: rtl/tcs_status_fmt.sv
// Builds the host-visible status byte and the attention event from the head slot.
// Assumes head flags are meaningless while the store is empty.
module tcs_status_fmt
    import tcs_pkg::*;
(
    input  logic       empty,
    input  tcs_flags_t head,
    output logic [7:0] sts_byte,
    output logic       evt
);
    // Byte layout: valid, five flags, two zero bits; all zero when empty.
    always_comb begin
        sts_byte = empty ? 8'h00 : {1'b1, head, 2'b00};
        evt      = !empty && (head != '0);
    end
endmodule

// File: rtl/tx_cmpl_stack.sv
// Transmit completion status stack: stores one status byte per finished frame,
// shows the oldest at the host port, pops on host write, and latches the
// transmitter off on jabber or underrun until a TX reset.
module tx_cmpl_stack
    import tcs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_valid,
    input  logic       cmp_irq_req,
    input  logic       cmp_jabber,
    input  logic       cmp_underrun,
    input  logic       cmp_max_coll,
    input  logic       host_wr,
    input  logic       tx_reset,
    output logic [7:0] sts_byte,
    output logic       tx_cmp_evt,
    output logic       tx_off
);
    tcs_flags_t in_flags, head;
    logic       empty;

    // Flags of the incoming completion; overflow always starts clear.
    always_comb begin
        in_flags          = '0;
        in_flags.irq_req  = cmp_irq_req;
        in_flags.jabber   = cmp_jabber;
        in_flags.underrun = cmp_underrun;
        in_flags.max_coll = cmp_max_coll;
    end

    tcs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tx_reset),
        .push       (cmp_valid),
        .push_flags (in_flags),
        .pop        (host_wr),
        .empty      (empty),
        .head_flags (head)
    );

    tcs_fault_latch u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_reset),
        .fault  (cmp_valid && (cmp_jabber || cmp_underrun)),
        .tx_off (tx_off)
    );

    tcs_status_fmt u_fmt (
        .empty    (empty),
        .head     (head),
        .sts_byte (sts_byte),
        .evt      (tx_cmp_evt)
    );

    // R9
    reset_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> (sts_byte == 8'h00 && !tx_cmp_evt));
endmodule

// File: tb/test_tx_cmpl_stack.sv
`timescale 1ns/1ps
module test_tx_cmpl_stack;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_valid = 1'b0, cmp_irq_req = 1'b0, cmp_jabber = 1'b0;
    logic       cmp_underrun = 1'b0, cmp_max_coll = 1'b0;
    logic       host_wr = 1'b0, tx_reset = 1'b0;
    logic [7:0] sts_byte;
    logic       tx_cmp_evt, tx_off;

    int checks = 0;
    int errors = 0;

    logic [7:0] mq[$];
    logic       m_off = 1'b0;

    always #2 clk = ~clk;

    tx_cmpl_stack i_tx_cmpl_stack (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_irq_req(cmp_irq_req),
        .cmp_jabber(cmp_jabber), .cmp_underrun(cmp_underrun), .cmp_max_coll(cmp_max_coll),
        .host_wr(host_wr), .tx_reset(tx_reset), .sts_byte(sts_byte),
        .tx_cmp_evt(tx_cmp_evt), .tx_off(tx_off)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [7:0] eb;
        eb = (mq.size() != 0) ? mq[0] : 8'h00;
        check(tag, "sts_byte", sts_byte, eb);
        check(tag, "tx_cmp_evt", tx_cmp_evt, (mq.size() != 0) && (eb[6:2] != 0));
        check(tag, "tx_off", tx_off, m_off);
    endtask

    // One cycle: drive after negedge, model at posedge, compare at next negedge.
    // f = {irq_req, jabber, underrun, max_coll}
    task automatic step(input logic push, input logic [3:0] f, input logic pop,
                        input logic rtx, input string tag);
        logic full, pop_ok;
        cmp_valid = push; {cmp_irq_req, cmp_jabber, cmp_underrun, cmp_max_coll} = f;
        host_wr = pop; tx_reset = rtx;
        @(posedge clk);
        if (rtx) begin
            mq.delete(); m_off = 1'b0;
        end else begin
            full   = (mq.size() == 4);
            pop_ok = pop && (mq.size() != 0);
            if (push && (f[2] || f[1])) m_off = 1'b1;
            if (push && full && !pop_ok) mq[3] = mq[3] | 8'h04;
            if (pop_ok) void'(mq.pop_front());
            if (push && !(full && !pop_ok)) mq.push_back({1'b1, f, 3'b000});
        end
        @(negedge clk);
        cmp_valid = 1'b0; host_wr = 1'b0; tx_reset = 1'b0;
        compare(tag);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R10");

        // R1 R7 R8: every flag combination, one at a time.
        for (int f = 0; f < 16; f++) begin
            step(1'b1, 4'(f), 1'b0, 1'b0, "R1");
            step(1'b0, 4'h0, 1'b0, 1'b0, "R8");
            step(1'b0, 4'h0, 1'b1, 1'b0, "R4");
            step(1'b0, 4'h0, 1'b0, 1'b1, "R9");
        end

        // R3: pop on empty has no effect.
        step(1'b0, 4'h0, 1'b1, 1'b0, "R3");
        // R2: fill with distinct patterns, then R5 overflow drops.
        step(1'b1, 4'h8, 1'b0, 1'b0, "R2");
        step(1'b1, 4'h1, 1'b0, 1'b0, "R2");
        step(1'b1, 4'h0, 1'b0, 1'b0, "R2");
        step(1'b1, 4'h9, 1'b0, 1'b0, "R2");
        step(1'b1, 4'h8, 1'b0, 1'b0, "R5");
        step(1'b1, 4'h4, 1'b0, 1'b0, "R5");
        // R6: push and pop together while full.
        step(1'b1, 4'h1, 1'b1, 1'b0, "R6");
        for (int k = 0; k < 5; k++) step(1'b0, 4'h0, 1'b1, 1'b0, "R3");
        // R9: reset with a simultaneous fault completion.
        step(1'b1, 4'h6, 1'b0, 1'b0, "R8");
        step(1'b1, 4'h6, 1'b0, 1'b1, "R9");

        // R2: pseudo-random mix of pushes, pops and rare resets.
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[11:8], lf[1] & lf[2], lf[7:3] == 5'd0, "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule